// File: doc/BRIEF.md
# Configurable Tile Register Bank

This block is the storage stage of a programmable logic tile: a bank of flip-flop cells that all see one tile clock, one clock-enable net and one set/reset net. How the bank reacts to those nets is decided at run time by configuration bits, not at design time. A tile-wide bit picks the capturing edge. Two tile-wide bits say whether the enable net and the set/reset net take part at all. Each cell then picks three things for itself: whether its output is registered or passed straight through from its data input, whether set/reset acts at once or waits for a clock edge, and whether set/reset forces a one or a zero.

Configuration enters through a serial port clocked by the system clock. Bits are shifted in most significant first, and a load strobe then copies the whole shift register into the live configuration in one step. While bits are being shifted the tile flip-flops are frozen. The load clears every flip-flop to zero so the tile starts from a known state.

Top module: `tile_ff_bank`

## Requirements
- R1: While rst_ni is low the live configuration is all zero, so every cell is bypassed and q_o equals d_i.
- R2: A cell whose used bit is 0 drives q_o[i] = d_i[i] combinationally, with no clock edge needed.
- R3: With the edge-select bit at 0, a used cell captures d_i on the rising edge of tile_clk_i.
- R4: With the edge-select bit at 1, a used cell captures d_i on the falling edge of tile_clk_i.
- R5: When the enable-used bit is 1, an active edge with tile_ce_i = 0 leaves the cell unchanged. When that bit is 0, tile_ce_i is ignored and every active edge captures.
- R6: When the set/reset-used bit is 0, tile_sr_i has no effect on any cell.
- R7: A cell with its async bit at 0 is forced by set/reset only on an active edge where the enable is active. While set/reset is high and no such edge occurs, the cell keeps its value.
- R8: A cell with its async bit at 1 is forced by set/reset at once, without a clock edge and regardless of the enable. After set/reset falls it keeps the forced value until the next capture.
- R9: The value forced by set/reset is 1 when the cell's set bit is 1 and 0 when it is 0.
- R10: While cfg_shift_i is high, used cells hold their values through any tile clock edge and any set/reset.
- R11: The chain is 3 + 3*N_CELLS bits, shifted in MSB first on clock edges where cfg_shift_i is high. Bit positions: bit [top] is edge select, [top-1] is enable-used, [top-2] is set/reset-used. Cell i then takes the bits [top-3-3i] used, [top-4-3i] async and [top-5-3i] set. A cfg_load_i pulse makes this the live configuration and clears every flip-flop to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for the configuration port |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_sdi_i | input | 1 | Serial configuration data |
| cfg_shift_i | input | 1 | Shift enable; also freezes the tile flip-flops |
| cfg_load_i | input | 1 | Copies the shift register into the live configuration |
| tile_clk_i | input | 1 | Shared tile clock |
| tile_ce_i | input | 1 | Shared clock enable |
| tile_sr_i | input | 1 | Shared set/reset |
| d_i | input | N_CELLS | Per-cell data inputs |
| q_o | output | N_CELLS | Per-cell registered or bypassed outputs |

## Verification
The bench changes d_i between the rising and falling edges of one tile clock pulse. A design that picks the wrong edge, or ignores the edge-select bit, therefore returns the other data word. Set/reset is raised with no tile edge and then with the enable low. A design that mixes up synchronous and asynchronous forcing, or lets a synchronous force bypass the enable, shows the wrong word at once. An asymmetric used mask together with mixed async and set masks exposes a chain unpacked in reverse or with its fields shifted. Pulsing the tile clock while cfg_shift_i is high catches a bank that does not freeze during configuration.

// File: rtl/tile_ff_pkg.sv
`timescale 1ns/1ps
package tile_ff_pkg;
  localparam int unsigned TILE_CFG_W = 3;
  localparam int unsigned CELL_CFG_W = 3;

  typedef struct packed {
    logic neg_clk;
    logic ce_used;
    logic sr_used;
  } tile_cfg_t;

  typedef struct packed {
    logic used;
    logic async_sr;
    logic set_val;
  } cell_cfg_t;
endpackage

// File: rtl/tile_cfg_chain.sv
`timescale 1ns/1ps
module tile_cfg_chain
  import tile_ff_pkg::*;
#(
  parameter int unsigned N_CELLS = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sdi_i,
  input  logic      shift_i,
  input  logic      load_i,
  output tile_cfg_t tile_cfg_o,
  output cell_cfg_t cell_cfg_o [N_CELLS],
  output logic      init_o
);
  localparam int unsigned CHAIN_W = TILE_CFG_W + N_CELLS * CELL_CFG_W;

  logic [CHAIN_W-1:0] shift_q;
  logic [CHAIN_W-1:0] live_q;
  logic               init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
    end else if (shift_i) begin
      shift_q <= {shift_q[CHAIN_W-2:0], sdi_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      init_q <= 1'b0;
    end else begin
      init_q <= load_i;
      if (load_i) live_q <= shift_q;
    end
  end

  assign tile_cfg_o = tile_cfg_t'(live_q[CHAIN_W-1 -: TILE_CFG_W]);
  assign init_o     = init_q;

  for (genvar g = 0; g < N_CELLS; g++) begin : g_unpack
    localparam int unsigned TOP = CHAIN_W - 1 - TILE_CFG_W - g * CELL_CFG_W;
    assign cell_cfg_o[g] = cell_cfg_t'(live_q[TOP -: CELL_CFG_W]);
  end
endmodule

// File: rtl/tile_ff_cell.sv
`timescale 1ns/1ps
module tile_ff_cell
  import tile_ff_pkg::*;
(
  input  logic      clk_i,
  input  logic      clr_i,
  input  cell_cfg_t cfg_i,
  input  logic      busy_i,
  input  logic      ce_i,
  input  logic      sr_i,
  input  logic      d_i,
  output logic      q_o
);
  logic ff_q;
  logic arst;

  // init clear wins over an asynchronous force; configuration freezes both
  assign arst = clr_i | (cfg_i.async_sr & sr_i & ~busy_i);

  always_ff @(posedge clk_i or posedge arst) begin
    if (arst) begin
      ff_q <= clr_i ? 1'b0 : cfg_i.set_val;
    end else if (ce_i && !busy_i) begin
      ff_q <= (sr_i && !cfg_i.async_sr) ? cfg_i.set_val : d_i;
    end
  end

  assign q_o = cfg_i.used ? ff_q : d_i;
endmodule

// File: rtl/tile_ff_bank.sv
`timescale 1ns/1ps
module tile_ff_bank
  import tile_ff_pkg::*;
#(
  parameter int unsigned N_CELLS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_sdi_i,
  input  logic               cfg_shift_i,
  input  logic               cfg_load_i,
  input  logic               tile_clk_i,
  input  logic               tile_ce_i,
  input  logic               tile_sr_i,
  input  logic [N_CELLS-1:0] d_i,
  output logic [N_CELLS-1:0] q_o
);
  tile_cfg_t tile_cfg;
  cell_cfg_t cell_cfg [N_CELLS];
  logic      cfg_init;
  logic      clk_eff;
  logic      ce_eff;
  logic      sr_eff;
  logic      clr;

  tile_cfg_chain #(.N_CELLS(N_CELLS)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sdi_i      (cfg_sdi_i),
    .shift_i    (cfg_shift_i),
    .load_i     (cfg_load_i),
    .tile_cfg_o (tile_cfg),
    .cell_cfg_o (cell_cfg),
    .init_o     (cfg_init)
  );

  assign clk_eff = tile_clk_i ^ tile_cfg.neg_clk;
  assign ce_eff  = tile_cfg.ce_used ? tile_ce_i : 1'b1;
  assign sr_eff  = tile_cfg.sr_used & tile_sr_i;
  assign clr     = ~rst_ni | cfg_init;

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    tile_ff_cell u_cell (
      .clk_i  (clk_eff),
      .clr_i  (clr),
      .cfg_i  (cell_cfg[g]),
      .busy_i (cfg_shift_i),
      .ce_i   (ce_eff),
      .sr_i   (sr_eff),
      .d_i    (d_i[g]),
      .q_o    (q_o[g])
    );
  end
endmodule

// File: rtl/tile_ff_bank_chk.sv
`timescale 1ns/1ps
module tile_ff_bank_chk
  import tile_ff_pkg::*;
#(
  parameter int unsigned N_CELLS = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_shift_i,
  input logic               tile_sr_i,
  input logic [N_CELLS-1:0] d_i,
  input logic [N_CELLS-1:0] q_o,
  input tile_cfg_t          tile_cfg_i,
  input cell_cfg_t          cell_cfg_i [N_CELLS],
  input logic               init_i
);
  logic [N_CELLS-1:0] used_m, async_m, set_m;

  always_comb begin
    for (int i = 0; i < N_CELLS; i++) begin
      used_m[i]  = cell_cfg_i[i].used;
      async_m[i] = cell_cfg_i[i].async_sr;
      set_m[i]   = cell_cfg_i[i].set_val;
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_bypass_R1: assert (q_o == d_i)
        else $error("reset: q_o %h d_i %h", q_o, d_i);
    end else begin
      assert_bypass_follows_R2: assert (((q_o ^ d_i) & ~used_m) == '0)
        else $error("bypassed cell differs from d_i");
      if (!init_i && !cfg_shift_i && tile_cfg_i.sr_used && tile_sr_i) begin
        assert_async_force_R8: assert (((q_o ^ set_m) & used_m & async_m) == '0)
          else $error("async cell not forced");
      end
    end
  end

  assert_hold_in_shift_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_shift_i && $past(cfg_shift_i) && !init_i && !$past(init_i) && $stable(used_m))
    |-> $stable(q_o & used_m));

  assert_load_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |-> ((q_o & used_m) == '0));
endmodule

bind tile_ff_bank tile_ff_bank_chk #(.N_CELLS(N_CELLS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_shift_i (cfg_shift_i),
  .tile_sr_i   (tile_sr_i),
  .d_i         (d_i),
  .q_o         (q_o),
  .tile_cfg_i  (tile_cfg),
  .cell_cfg_i  (cell_cfg),
  .init_i      (cfg_init)
);

// File: tb/tile_ff_bank_bench.sv
`timescale 1ns/1ps
module tile_ff_bank_bench;
  localparam int unsigned N  = 8;
  localparam int unsigned CW = 3 + 3 * N;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cfg_sdi_i = 1'b0, cfg_shift_i = 1'b0, cfg_load_i = 1'b0;
  logic         tile_clk_i = 1'b0, tile_ce_i = 1'b1, tile_sr_i = 1'b0;
  logic [N-1:0] d_i = '0;
  logic [N-1:0] q_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  tile_ff_bank #(.N_CELLS(N)) u_tile_ff_bank (
    .clk_i, .rst_ni, .cfg_sdi_i, .cfg_shift_i, .cfg_load_i,
    .tile_clk_i, .tile_ce_i, .tile_sr_i, .d_i, .q_o
  );

  always #2.5 clk_i = ~clk_i;

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic load_cfg(input logic neg, input logic ceu, input logic sru,
                          input logic [N-1:0] used, input logic [N-1:0] asy,
                          input logic [N-1:0] setv);
    logic [CW-1:0] v;
    v[CW-1] = neg; v[CW-2] = ceu; v[CW-3] = sru;
    for (int i = 0; i < N; i++) begin
      v[CW-4-3*i] = used[i];
      v[CW-5-3*i] = asy[i];
      v[CW-6-3*i] = setv[i];
    end
    for (int b = CW - 1; b >= 0; b--) begin
      @(posedge clk_i); #1 cfg_shift_i = 1'b1; cfg_sdi_i = v[b];
    end
    @(posedge clk_i); #1 cfg_shift_i = 1'b0; cfg_load_i = 1'b1;
    @(posedge clk_i); #1 cfg_load_i = 1'b0;
    @(posedge clk_i); #1;
  endtask

  // d_a present at the rising tile edge, d_b at the falling one
  task automatic tile_pulse(input logic [N-1:0] d_a, input logic [N-1:0] d_b);
    @(posedge clk_i); #1 d_i = d_a; #1 tile_clk_i = 1'b1;
    @(posedge clk_i); #1 d_i = d_b; #1 tile_clk_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    d_i = 8'h5A; @(negedge clk_i);
    check("R1 reset bypass", q_o, 8'h5A);
    d_i = 8'hC3; #1;
    check("R1 R2 reset bypass follows d", q_o, 8'hC3);
    @(posedge clk_i); #1 rst_ni = 1'b1;
  endtask

  task automatic t_rise();
    d_i = 8'hFF;
    load_cfg(1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h00);
    @(negedge clk_i);
    check("R11 load clears used cells", q_o, 8'h00);
    tile_pulse(8'h96, 8'h00);
    check("R3 rising edge capture", q_o, 8'h96);
    tile_sr_i = 1'b1;
    tile_pulse(8'h3C, 8'h00);
    check("R6 unused set/reset ignored", q_o, 8'h3C);
    tile_sr_i = 1'b0; tile_ce_i = 1'b0;
    tile_pulse(8'h81, 8'h00);
    check("R5 unused enable ignored", q_o, 8'h81);
    tile_ce_i = 1'b1;
  endtask

  task automatic t_fall();
    load_cfg(1'b1, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h00);
    @(negedge clk_i);
    check("R11 load clears after edge change", q_o, 8'h00);
    tile_pulse(8'h11, 8'hEE);
    check("R4 falling edge capture", q_o, 8'hEE);
  endtask

  task automatic t_enable();
    load_cfg(1'b0, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h00);
    tile_pulse(8'h77, 8'h00);
    check("R5 enable high captures", q_o, 8'h77);
    tile_ce_i = 1'b0;
    tile_pulse(8'h08, 8'h00);
    check("R5 enable low holds", q_o, 8'h77);
    tile_ce_i = 1'b1;
  endtask

  task automatic t_sync();
    load_cfg(1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, 8'hA5);
    tile_pulse(8'h0F, 8'h00);
    check("R7 sync setup capture", q_o, 8'h0F);
    @(posedge clk_i); #1 tile_sr_i = 1'b1;
    @(negedge clk_i);
    check("R7 sync waits for edge", q_o, 8'h0F);
    tile_pulse(8'h00, 8'h00);
    check("R7 R9 sync force on edge", q_o, 8'hA5);
    tile_sr_i = 1'b0;
    tile_pulse(8'h3C, 8'h00);
    check("R7 capture after release", q_o, 8'h3C);
    tile_sr_i = 1'b1; tile_ce_i = 1'b0;
    tile_pulse(8'h00, 8'h00);
    check("R7 sync blocked by enable", q_o, 8'h3C);
    tile_sr_i = 1'b0; tile_ce_i = 1'b1;
  endtask

  task automatic t_async();
    load_cfg(1'b0, 1'b1, 1'b1, 8'hFF, 8'h0F, 8'h3C);
    tile_pulse(8'h99, 8'h00);
    check("R8 async setup capture", q_o, 8'h99);
    tile_ce_i = 1'b0;
    @(posedge clk_i); #1 tile_sr_i = 1'b1;
    @(negedge clk_i);
    check("R8 R9 async force without edge", q_o, 8'h9C);
    @(posedge clk_i); #1 tile_sr_i = 1'b0;
    @(negedge clk_i);
    check("R8 forced value kept", q_o, 8'h9C);
    tile_pulse(8'h00, 8'h00);
    check("R8 held with enable low", q_o, 8'h9C);
    tile_ce_i = 1'b1;
  endtask

  task automatic t_mixed();
    d_i = 8'hFF;
    load_cfg(1'b0, 1'b0, 1'b0, 8'h33, 8'h00, 8'h00);
    @(negedge clk_i);
    check("R11 field positions used mask", q_o, 8'hCC);
    tile_pulse(8'hAA, 8'h55);
    check("R2 R3 mixed capture", q_o, 8'h66);
    @(posedge clk_i); #1 d_i = 8'h0F;
    #1 check("R2 bypass combinational", q_o, 8'h2E);
  endtask

  task automatic t_hold();
    load_cfg(1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h00);
    tile_pulse(8'h5A, 8'h00);
    check("R10 setup capture", q_o, 8'h5A);
    @(posedge clk_i); #1 cfg_shift_i = 1'b1; cfg_sdi_i = 1'b0;
    tile_pulse(8'hA5, 8'h00);
    check("R10 hold while shifting", q_o, 8'h5A);
    @(posedge clk_i); #1 cfg_shift_i = 1'b0;
    tile_pulse(8'hA5, 8'h00);
    check("R10 capture after shift ends", q_o, 8'hA5);
  endtask

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_enable();
    t_sync();
    t_async();
    t_mixed();
    t_hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 got hung exp done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule